// File: doc/BRIEF.md
# Dual-Issue Pairing Decision Logic

This block sits between predecode and issue in a two-wide in-order pipeline. Each cycle it looks at the two oldest fetched instructions, called slot A (older) and slot B (younger). It decides whether both may leave together or only slot A leaves. Each slot is described by:

- a valid bit;
- a two-bit class code;
- a branch flag;
- a write-enable flag;
- a destination register number.

Slot B also carries a flag that is set when it lies across a cache-line or page boundary from slot A.

The decision is purely combinational. The rules cover three things: which class combinations are legal, the restriction that a branch may only be the younger member of a pair, and the restriction on pairs that straddle a boundary. When a pair issues and both members write the same register, the block also reports that the older write must be dropped, so the younger result is the one that survives. The pair's start address plays no part in the decision, so no address input exists.

A parameter chooses between two class-rule variants: one that lets two integer operations pair, and one that does not. A second parameter sets the register-number width.

Top module: `dual_issue_pair`

## Requirements
- R1: Class codes are 0 = integer, 1 = load/store, 2 = floating point, 3 = reserved. Two valid, non-branch slots whose classes are different codes in the range 0..2 issue together, provided slot A is not a branch and no boundary rule forbids it.
- R2: With ALLOW_INT_PAIR = 1, two integer slots issue together. With ALLOW_INT_PAIR = 0, two integer slots never issue together.
- R3: The following never issue together: two load/store slots, two floating-point slots, or any pair in which either slot has the reserved class 3.
- R4: A slot with its branch flag set is treated as class integer, whatever its class field holds.
- R5: When slot A is a branch, the pair never issues together. A branch in slot B does not by itself prevent pairing.
- R6: When slot B's boundary flag is set, the pair issues together only if slot B is a floating-point, non-branch instruction. Otherwise only slot A issues.
- R7: If slot B is not valid, only slot A issues. If slot A is not valid, neither issue output is asserted.
- R8: `issue_both` and `issue_first_only` are never high together. When slot A is valid, exactly one of them is high.
- R9: A pair that writes the same destination register from both slots still issues together. In that case `first_wr_drop` is 1, so slot B's result is kept. `first_wr_drop` is 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_vld | input | 1 | Slot A (older) holds an instruction |
| a_cls | input | 2 | Slot A class code |
| a_br | input | 1 | Slot A is a branch |
| a_wr | input | 1 | Slot A writes a register |
| a_dst | input | REG_W | Slot A destination register |
| b_vld | input | 1 | Slot B (younger) holds an instruction |
| b_cls | input | 2 | Slot B class code |
| b_br | input | 1 | Slot B is a branch |
| b_xing | input | 1 | Slot B lies across a line or page boundary from slot A |
| b_wr | input | 1 | Slot B writes a register |
| b_dst | input | REG_W | Slot B destination register |
| issue_both | output | 1 | Both slots issue this cycle |
| issue_first_only | output | 1 | Only slot A issues this cycle |
| first_wr_drop | output | 1 | Slot A's register write is discarded in favour of slot B's |

## Verification
The bench builds two copies side by side, driven from the same stimulus. The first uses the defaults: integer pairing enabled and 5-bit register numbers. The second uses integer pairing disabled and 3-bit register numbers. Running both lets every class, branch, boundary and valid combination be compared under both variants of the class rule. The narrow copy also shows that destination equality is judged only on the register bits that exist, because its slots alias when the wide copy's slots differ only in the upper bits.

// File: rtl/pair_pkg.sv
package pair_pkg;
   localparam int CLS_W = 2;

   typedef enum logic [CLS_W-1:0] {
      CLS_INT = 2'd0,
      CLS_MEM = 2'd1,
      CLS_FP  = 2'd2,
      CLS_RSV = 2'd3
   } op_class_e;
endpackage

// File: rtl/pair_class_norm.sv
module pair_class_norm
   import pair_pkg::*;
(
   input  logic [CLS_W-1:0] cls_in,
   input  logic             br_in,
   output logic [CLS_W-1:0] cls_eff
);
   // A branch is an integer-class operation regardless of the encoded class.
   always_comb begin
      cls_eff = br_in ? CLS_INT : cls_in;
   end
endmodule

// File: rtl/pair_class_rule.sv
module pair_class_rule
   import pair_pkg::*;
#(
   parameter bit ALLOW_INT_PAIR = 1'b1
) (
   input  logic [CLS_W-1:0] cls_a,
   input  logic [CLS_W-1:0] cls_b,
   output logic             class_ok
);
   logic rsv_seen;
   logic differ;
   logic both_int;

   always_comb begin
      rsv_seen = (cls_a == CLS_RSV) || (cls_b == CLS_RSV);
      differ   = (cls_a != cls_b);
      both_int = (cls_a == CLS_INT) && (cls_b == CLS_INT);
   end

   generate
      if (ALLOW_INT_PAIR) begin : g_int_pair
         always_comb class_ok = !rsv_seen && (differ || both_int);
      end else begin : g_no_int_pair
         always_comb class_ok = !rsv_seen && differ;
      end
   endgenerate
endmodule

// File: rtl/pair_boundary_rule.sv
module pair_boundary_rule
   import pair_pkg::*;
(
   input  logic             b_xing,
   input  logic [CLS_W-1:0] b_cls_eff,
   output logic             cross_ok
);
   // Only a floating-point younger slot may straddle a line or page edge.
   always_comb begin
      cross_ok = !b_xing || (b_cls_eff == CLS_FP);
   end
endmodule

// File: rtl/pair_dest_merge.sv
module pair_dest_merge #(
   parameter int REG_W = 5
) (
   input  logic             pair_go,
   input  logic             a_wr,
   input  logic             b_wr,
   input  logic [REG_W-1:0] a_dst,
   input  logic [REG_W-1:0] b_dst,
   output logic             first_wr_drop
);
   logic same_dst;

   always_comb begin
      same_dst      = (a_dst == b_dst);
      first_wr_drop = pair_go && a_wr && b_wr && same_dst;
   end
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
   import pair_pkg::*;
#(
   parameter int REG_W          = 5,
   parameter bit ALLOW_INT_PAIR = 1'b1
) (
   input  logic             a_vld,
   input  logic [1:0]       a_cls,
   input  logic             a_br,
   input  logic             a_wr,
   input  logic [REG_W-1:0] a_dst,
   input  logic             b_vld,
   input  logic [1:0]       b_cls,
   input  logic             b_br,
   input  logic             b_xing,
   input  logic             b_wr,
   input  logic [REG_W-1:0] b_dst,
   output logic             issue_both,
   output logic             issue_first_only,
   output logic             first_wr_drop
);
   localparam int SLOTS = 2;

   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_reg_w
         $error("dual_issue_pair: REG_W must be in 1..8");
      end
   endgenerate

   logic [CLS_W-1:0] cls_raw [SLOTS];
   logic             br_raw  [SLOTS];
   logic [CLS_W-1:0] cls_eff [SLOTS];

   always_comb begin
      cls_raw[0] = a_cls;
      cls_raw[1] = b_cls;
      br_raw[0]  = a_br;
      br_raw[1]  = b_br;
   end

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_norm
         pair_class_norm u_norm (
            .cls_in  (cls_raw[s]),
            .br_in   (br_raw[s]),
            .cls_eff (cls_eff[s])
         );
      end
   endgenerate

   logic class_ok;
   logic cross_ok;
   logic pair_go;

   pair_class_rule #(.ALLOW_INT_PAIR(ALLOW_INT_PAIR)) u_class (
      .cls_a    (cls_eff[0]),
      .cls_b    (cls_eff[1]),
      .class_ok (class_ok)
   );

   pair_boundary_rule u_bound (
      .b_xing    (b_xing),
      .b_cls_eff (cls_eff[1]),
      .cross_ok  (cross_ok)
   );

   always_comb begin
      pair_go          = a_vld && b_vld && !a_br && class_ok && cross_ok;
      issue_both       = pair_go;
      issue_first_only = a_vld && !pair_go;
   end

   pair_dest_merge #(.REG_W(REG_W)) u_dest (
      .pair_go       (pair_go),
      .a_wr          (a_wr),
      .b_wr          (b_wr),
      .a_dst         (a_dst),
      .b_dst         (b_dst),
      .first_wr_drop (first_wr_drop)
   );
endmodule

// File: rtl/dual_issue_pair_chk.sv
module dual_issue_pair_chk #(
   parameter int REG_W = 5
) (
   input logic             a_vld,
   input logic [1:0]       a_cls,
   input logic             a_br,
   input logic             b_vld,
   input logic [1:0]       b_cls,
   input logic             b_br,
   input logic             b_xing,
   input logic [REG_W-1:0] a_dst,
   input logic [REG_W-1:0] b_dst,
   input logic             issue_both,
   input logic             issue_first_only,
   input logic             first_wr_drop
);
   always_comb begin
      a_r8_exclusive: assert (!(issue_both && issue_first_only))
         else $error("R8: both issue outputs high");
      a_r7_no_slot_a: assert (a_vld || (!issue_both && !issue_first_only))
         else $error("R7: issue with slot A empty");
      a_r5_branch_first: assert (!(a_vld && a_br && issue_both))
         else $error("R5: older branch paired");
      a_r3_mem_mem: assert (!(a_cls == 2'd1 && b_cls == 2'd1 && !a_br && !b_br
                              && issue_both))
         else $error("R3: two load/store paired");
      a_r6_cross: assert (!(b_xing && (b_cls != 2'd2 || b_br) && issue_both))
         else $error("R6: non-FP pair across boundary");
      a_r9_drop: assert (!first_wr_drop || (issue_both && a_dst == b_dst))
         else $error("R9: write drop without same-dest pair");
   end
endmodule

bind dual_issue_pair dual_issue_pair_chk #(.REG_W(REG_W)) u_chk (
   .a_vld            (a_vld),
   .a_cls            (a_cls),
   .a_br             (a_br),
   .b_vld            (b_vld),
   .b_cls            (b_cls),
   .b_br             (b_br),
   .b_xing           (b_xing),
   .a_dst            (a_dst),
   .b_dst            (b_dst),
   .issue_both       (issue_both),
   .issue_first_only (issue_first_only),
   .first_wr_drop    (first_wr_drop)
);

// File: tb/dual_issue_pair_test.sv
module dual_issue_pair_test;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       a_vld, a_br, a_wr, b_vld, b_br, b_xing, b_wr;
   logic [1:0] a_cls, b_cls;
   logic [4:0] a_dst, b_dst;
   logic       both, first, drop, both_l, first_l, drop_l;

   dual_issue_pair uut (
      .a_vld(a_vld), .a_cls(a_cls), .a_br(a_br), .a_wr(a_wr), .a_dst(a_dst),
      .b_vld(b_vld), .b_cls(b_cls), .b_br(b_br), .b_xing(b_xing),
      .b_wr(b_wr), .b_dst(b_dst),
      .issue_both(both), .issue_first_only(first), .first_wr_drop(drop)
   );

   dual_issue_pair #(.REG_W(3), .ALLOW_INT_PAIR(1'b0)) uut_legacy (
      .a_vld(a_vld), .a_cls(a_cls), .a_br(a_br), .a_wr(a_wr), .a_dst(a_dst[2:0]),
      .b_vld(b_vld), .b_cls(b_cls), .b_br(b_br), .b_xing(b_xing),
      .b_wr(b_wr), .b_dst(b_dst[2:0]),
      .issue_both(both_l), .issue_first_only(first_l), .first_wr_drop(drop_l)
   );

   typedef struct {
      logic  both, first, drop, both_l, first_l, drop_l;
      string tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;

   function automatic void model(input logic av, input logic [1:0] ac,
      input logic abr, input logic aw, input logic [4:0] ad,
      input logic bv, input logic [1:0] bc, input logic bbr, input logic bx,
      input logic bw, input logic [4:0] bd, input bit allow, input int rw,
      output logic o_both, output logic o_first, output logic o_drop);
      logic [1:0] ea, eb;
      logic       cls_ok, x_ok, same;
      ea = abr ? 2'd0 : ac;                          // R4
      eb = bbr ? 2'd0 : bc;
      if (ea == 2'd3 || eb == 2'd3) cls_ok = 1'b0;   // R3
      else if (ea != eb)            cls_ok = 1'b1;   // R1
      else if (ea == 2'd0)          cls_ok = allow;  // R2
      else                          cls_ok = 1'b0;   // R3
      x_ok    = !bx || (eb == 2'd2);                 // R6
      o_both  = av && bv && !abr && cls_ok && x_ok;  // R5 R7
      o_first = av && !o_both;                       // R8
      same    = (rw == 5) ? (ad == bd) : (ad[2:0] == bd[2:0]);
      o_drop  = o_both && aw && bw && same;          // R9
   endfunction

   function automatic string pick_tag(input logic av, input logic [1:0] ac,
      input logic abr, input logic bv, input logic [1:0] bc, input logic bbr,
      input logic bx);
      if (!av || !bv) return "R7";
      if (abr)        return "R5";
      if (bx)         return "R6";
      if (bbr)        return "R4";
      if (ac == 2'd0 && bc == 2'd0) return "R2";
      if (ac == bc || ac == 2'd3 || bc == 2'd3) return "R3";
      return "R1";
   endfunction

   task automatic drive(input logic av, input logic [1:0] ac, input logic abr,
      input logic aw, input logic [4:0] ad, input logic bv, input logic [1:0] bc,
      input logic bbr, input logic bx, input logic bw, input logic [4:0] bd,
      input string tag_over);
      exp_t e;
      @(negedge clk);
      a_vld = av; a_cls = ac; a_br = abr; a_wr = aw; a_dst = ad;
      b_vld = bv; b_cls = bc; b_br = bbr; b_xing = bx; b_wr = bw; b_dst = bd;
      model(av, ac, abr, aw, ad, bv, bc, bbr, bx, bw, bd, 1'b1, 5,
            e.both, e.first, e.drop);
      model(av, ac, abr, aw, ad, bv, bc, bbr, bx, bw, bd, 1'b0, 3,
            e.both_l, e.first_l, e.drop_l);
      e.tag = (tag_over != "") ? tag_over : pick_tag(av, ac, abr, bv, bc, bbr, bx);
      q.push_back(e);
   endtask

   task automatic cmp(input logic act, input logic exp, input string tag,
                      input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   // Monitor: compare one expected item per cycle, sampled after the edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(both,    e.both,    e.tag, "issue_both");
            cmp(first,   e.first,   e.tag, "issue_first_only");
            cmp(drop,    e.drop,    "R9",  "first_wr_drop");
            cmp(both_l,  e.both_l,  e.tag, "legacy issue_both");
            cmp(first_l, e.first_l, e.tag, "legacy issue_first_only");
            cmp(drop_l,  e.drop_l,  "R9",  "legacy first_wr_drop");
            cmp(both && first, 1'b0, "R8", "exclusive outputs");
         end
      end
   end

   initial begin
      #(200000 * 4);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      // Idle state: nothing valid, no issue and no write drop (R7).
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
      // Full sweep of validity, class, branch and boundary combinations.
      for (int av = 0; av < 2; av++)
         for (int bv = 0; bv < 2; bv++)
            for (int ac = 0; ac < 4; ac++)
               for (int bc = 0; bc < 4; bc++)
                  for (int ab = 0; ab < 2; ab++)
                     for (int bb = 0; bb < 2; bb++)
                        for (int bx = 0; bx < 2; bx++)
                           drive(av[0], ac[1:0], ab[0], 1'b1, 5'd7, bv[0],
                                 bc[1:0], bb[0], bx[0], 1'b1,
                                 ((ac + bc) % 2 == 0) ? 5'd7 : 5'd9, "");
      // R9: same destination on pairing and non-pairing combinations.
      drive(1, 0, 0, 1, 5'd3,  1, 1, 0, 0, 1, 5'd3,  "R9");
      drive(1, 0, 0, 1, 5'd3,  1, 1, 0, 0, 0, 5'd3,  "R9");
      drive(1, 0, 0, 0, 5'd3,  1, 2, 0, 0, 1, 5'd3,  "R9");
      drive(1, 1, 0, 1, 5'd3,  1, 1, 0, 0, 1, 5'd3,  "R9");
      drive(1, 0, 0, 1, 5'd3,  1, 0, 0, 0, 1, 5'd3,  "R9");
      drive(1, 0, 0, 1, 5'd4,  1, 1, 0, 0, 1, 5'd12, "R9");
      drive(1, 2, 0, 1, 5'd31, 1, 0, 1, 0, 1, 5'd31, "R9");
      repeat (4) @(posedge clk);
      #1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule